// File: doc/BRIEF.md
# Multi-Lane Serial Shift Engine

This block converts parallel data words into a synchronous serial stream, and back again, over one, two or four data lanes at once. A static control word selects the bit order, the level that idle outputs sit at, the number of lanes, whether transmitted data is inverted, how an external shift-control line gates the start of a frame, the word length (1 to 16 bits) and the frame length (1 to 64 bits). Timing comes from a shift-enable pulse supplied from outside. Each pulse moves one group of bits: one bit per active lane.

On the parallel side, transmit words are taken with a valid/ready handshake. Received words come back with a one-cycle valid strobe. A frame longer than one word is cut into words of the programmed length, and the last word may be shorter. A new transmit word is fetched at each word boundary. If none is on offer, the frame is cut short and an underrun pulse is raised.

Top module: `mlane_shift_engine`

## Requirements
- R1: After reset, all data outputs are 0, `busy`, `rx_valid` and `underrun` are 0, and `tx_ready` stays 0 even when `shift_en` and `tx_valid` are high (the gate mode resets to 0).
- R2: With `cfg_msb_first`=0, the first shift step of a word drives word bit 0, the next step drives bit 1, and so on.
- R3: With `cfg_msb_first`=1, the first bit shifted out of an n-bit word is bit n-1, not bit 15. After that the bit positions count down.
- R4: `cfg_word_len` holds the word length minus one: code 0 gives a 1-bit word in bit [0], and code 15 gives a 16-bit word in bits [15:0].
- R5: `cfg_lane_mode` code 0 uses lane 0 only, code 2 uses lanes 1:0 and code 3 uses lanes 3:0. The reserved code 1 behaves like code 0. Lane k carries the k-th bit of each group, in shift order. Lanes that have no bit in a step, including the spare lanes of a partial last step, drive the passive level.
- R6: While no frame is active, every `dout` lane drives `cfg_idle_lvl`.
- R7: With `cfg_invert`=1, data bits leave the block inverted. The passive level is never inverted.
- R8: `cfg_gate` sets when a frame may start. Code 0: never. Code 1: while `sctl` is 1. Code 2: while `sctl` is 0. Code 3: once after each change of `sctl`, and the edge is consumed when the frame starts.
- R9: `cfg_frame_len` holds the frame length minus one. A frame is sent as consecutive words of `cfg_word_len`+1 bits, and the last word holds whatever bits remain.
- R10: At the shift pulse that completes a word, the received word is presented on `rx_data`, with bits placed at the same positions the transmit bits were taken from. `rx_valid` is high for that one cycle only, and unused bits are 0.
- R11: Control inputs that change while a frame is active have no effect on that frame.
- R12: If `tx_valid` is low at a word boundary inside a frame, the frame ends, the outputs return to the passive level and `underrun` pulses for one cycle.
- R13: `tx_ready` is high only during a shift pulse at which a word is taken: a frame start that the gate permits, or a word boundary with bits still to send. A word moves only when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_msb_first | input | 1 | 1: highest used bit goes first; 0: bit 0 goes first |
| cfg_idle_lvl | input | 1 | Passive level for idle and unused lanes |
| cfg_lane_mode | input | 2 | Lane count code (0: 1 lane, 2: 2 lanes, 3: 4 lanes) |
| cfg_invert | input | 1 | Invert transmitted data bits |
| cfg_gate | input | 2 | Frame-start gating rule for `sctl` |
| cfg_frame_len | input | 6 | Frame length minus one, in bits |
| cfg_word_len | input | 4 | Word length minus one, in bits |
| shift_en | input | 1 | One-cycle shift-step pulse |
| sctl | input | 1 | Shift-control line |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word on offer |
| tx_ready | output | 1 | Transmit word taken this cycle if valid |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| din | input | 4 | Serial input lanes |
| dout | output | 4 | Serial output lanes |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | One-cycle pulse on a frame cut short |

## Verification
Frames are run under directed settings and under fixed-seed random settings, with random words and random input-lane data. Every output group is compared with a model of the lane, bit-order and inversion rules, so a wrong bit position, a wrong lane order or a misplaced inversion each give a different mismatch. Word lengths that do not divide evenly by the lane count show whether the spare lanes of a partial step drive the passive level. Frames longer than one word, including the largest 64-bit frame and 1-bit words, show whether the word split and the shortened last word are right. Separate runs cover each gating code with the control line high, low and toggled, a frame whose control inputs are changed while it runs, and a frame that runs out of transmit words.

// File: rtl/mls_pkg.sv
package mls_pkg;

   typedef enum logic [1:0] {
      GATE_OFF  = 2'd0,
      GATE_HIGH = 2'd1,
      GATE_LOW  = 2'd2,
      GATE_EDGE = 2'd3
   } gate_mode_e;

   // lane count selected by the lane-mode code; reserved code 1 runs one lane
   function automatic int unsigned lanes_for_code(input logic [1:0] code);
      case (code)
         2'd2:    return 2;
         2'd3:    return 4;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/mls_gate.sv
module mls_gate
   import mls_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sctl,
   input  gate_mode_e mode,
   input  logic       consume,
   output logic       ok
);

   logic sctl_q;
   logic pend_q;
   logic chg;

   assign chg = sctl ^ sctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sctl_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         sctl_q <= sctl;
         if (chg)
            pend_q <= 1'b1;
         else if (consume)
            pend_q <= 1'b0;
      end
   end

   always_comb begin
      case (mode)
         GATE_HIGH: ok = sctl;
         GATE_LOW:  ok = ~sctl;
         GATE_EDGE: ok = pend_q;
         default:   ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/mls_word_size.sv
module mls_word_size #(
   parameter int IDX_W  = 5,
   parameter int FCNT_W = 7
) (
   input  logic [FCNT_W-1:0] remain,
   input  logic [IDX_W-1:0]  wsz,
   output logic [IDX_W-1:0]  n,
   output logic [FCNT_W-1:0] rest
);

   localparam int CW = (FCNT_W > IDX_W) ? FCNT_W : IDX_W;

   logic [CW-1:0] r_e;
   logic [CW-1:0] w_e;
   logic [CW-1:0] n_e;

   assign r_e  = CW'(remain);
   assign w_e  = CW'(wsz);
   assign n_e  = (r_e < w_e) ? r_e : w_e;
   assign n    = IDX_W'(n_e);
   assign rest = FCNT_W'(r_e - n_e);

endmodule

// File: rtl/mls_lane_map.sv
module mls_lane_map #(
   parameter int DATA_W = 16,
   parameter int LANES  = 4,
   parameter int IDX_W  = 5
) (
   input  logic              active,
   input  logic              msb_first,
   input  logic              invert,
   input  logic              idle_lvl,
   input  logic [IDX_W-1:0]  lane_cnt,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [IDX_W-1:0]  word_n,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [DATA_W-1:0] rx_acc,
   input  logic [LANES-1:0]  din,
   output logic [LANES-1:0]  dout,
   output logic [DATA_W-1:0] rx_next
);

   localparam int WLEN_W = $clog2(DATA_W);

   logic [DATA_W-1:0] set_vec [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [IDX_W:0]    idx;
      logic [IDX_W:0]    down;
      logic              use_k;
      logic [WLEN_W-1:0] pos;

      assign idx   = {1'b0, bit_idx} + (IDX_W+1)'(k);
      assign down  = {1'b0, word_n} - idx - (IDX_W+1)'(1);
      assign use_k = active && ((IDX_W+1)'(k) < {1'b0, lane_cnt})
                     && (idx < {1'b0, word_n});
      assign pos   = msb_first ? WLEN_W'(down) : WLEN_W'(idx);

      assign dout[k]    = use_k ? (tx_word[pos] ^ invert) : idle_lvl;
      assign set_vec[k] = (use_k && din[k]) ? (DATA_W'(1) << pos) : '0;
   end

   always_comb begin
      rx_next = rx_acc;
      for (int k = 0; k < LANES; k++)
         rx_next = rx_next | set_vec[k];
   end

endmodule

// File: rtl/mlane_shift_engine.sv
module mlane_shift_engine
   import mls_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int FLEN_W = 6,
   parameter int LANES  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_msb_first,
   input  logic                       cfg_idle_lvl,
   input  logic [1:0]                 cfg_lane_mode,
   input  logic                       cfg_invert,
   input  logic [1:0]                 cfg_gate,
   input  logic [FLEN_W-1:0]          cfg_frame_len,
   input  logic [$clog2(DATA_W)-1:0]  cfg_word_len,
   input  logic                       shift_en,
   input  logic                       sctl,
   input  logic [DATA_W-1:0]          tx_data,
   input  logic                       tx_valid,
   output logic                       tx_ready,
   output logic [DATA_W-1:0]          rx_data,
   output logic                       rx_valid,
   input  logic [LANES-1:0]           din,
   output logic [LANES-1:0]           dout,
   output logic                       busy,
   output logic                       underrun
);

   localparam int WLEN_W = $clog2(DATA_W);
   localparam int IDX_W  = WLEN_W + 1;
   localparam int FCNT_W = FLEN_W + 1;

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 2");
   end
   if (LANES != 1 && LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("LANES must be 1, 2 or 4");
   end
   if (LANES > DATA_W) begin : g_bad_ratio
      $error("LANES may not exceed DATA_W");
   end

   // latched frame settings
   logic               busy_q;
   logic               msb_q, idle_q, inv_q;
   logic [IDX_W-1:0]   lanes_q;
   logic [IDX_W-1:0]   wlen_q;
   // per-word progress
   logic [DATA_W-1:0]  tx_word_q;
   logic [DATA_W-1:0]  rx_acc_q;
   logic [IDX_W-1:0]   bit_idx_q;
   logic [IDX_W-1:0]   word_n_q;
   logic [FCNT_W-1:0]  left_q;
   // outputs
   logic [DATA_W-1:0]  rx_data_q;
   logic               rx_valid_q;
   logic               underrun_q;

   logic [IDX_W-1:0]   lanes_live;
   logic [IDX_W-1:0]   wsz_live;
   logic [FCNT_W-1:0]  total_bits;
   logic [IDX_W:0]     step_end;
   logic               word_end;
   logic               more;
   logic               gate_ok;
   logic               start_go;
   logic [FCNT_W-1:0]  ws_remain;
   logic [IDX_W-1:0]   ws_wsz;
   logic [IDX_W-1:0]   ws_n;
   logic [FCNT_W-1:0]  ws_rest;
   logic [DATA_W-1:0]  rx_next;

   always_comb begin
      int unsigned lc;
      lc = lanes_for_code(cfg_lane_mode);
      if (lc > LANES)
         lc = LANES;
      lanes_live = IDX_W'(lc);
   end

   assign wsz_live   = {1'b0, cfg_word_len} + IDX_W'(1);
   assign total_bits = {1'b0, cfg_frame_len} + FCNT_W'(1);
   assign step_end   = {1'b0, bit_idx_q} + {1'b0, lanes_q};
   assign word_end   = busy_q && (step_end >= {1'b0, word_n_q});
   assign more       = (left_q != '0);

   assign tx_ready = shift_en && (busy_q ? (word_end && more) : gate_ok);
   assign start_go = !busy_q && shift_en && gate_ok && tx_valid;

   assign ws_remain = busy_q ? left_q : total_bits;
   assign ws_wsz    = busy_q ? wlen_q : wsz_live;

   mls_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .sctl    (sctl),
      .mode    (gate_mode_e'(cfg_gate)),
      .consume (start_go),
      .ok      (gate_ok)
   );

   mls_word_size #(.IDX_W(IDX_W), .FCNT_W(FCNT_W)) u_word_size (
      .remain (ws_remain),
      .wsz    (ws_wsz),
      .n      (ws_n),
      .rest   (ws_rest)
   );

   mls_lane_map #(.DATA_W(DATA_W), .LANES(LANES), .IDX_W(IDX_W)) u_lane_map (
      .active    (busy_q),
      .msb_first (msb_q),
      .invert    (inv_q),
      .idle_lvl  (busy_q ? idle_q : cfg_idle_lvl),
      .lane_cnt  (lanes_q),
      .bit_idx   (bit_idx_q),
      .word_n    (word_n_q),
      .tx_word   (tx_word_q),
      .rx_acc    (rx_acc_q),
      .din       (din),
      .dout      (dout),
      .rx_next   (rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         msb_q      <= 1'b0;
         idle_q     <= 1'b0;
         inv_q      <= 1'b0;
         lanes_q    <= IDX_W'(1);
         wlen_q     <= IDX_W'(1);
         tx_word_q  <= '0;
         rx_acc_q   <= '0;
         bit_idx_q  <= '0;
         word_n_q   <= IDX_W'(1);
         left_q     <= '0;
         rx_data_q  <= '0;
         rx_valid_q <= 1'b0;
         underrun_q <= 1'b0;
      end else begin
         rx_valid_q <= 1'b0;
         underrun_q <= 1'b0;
         if (!busy_q) begin
            if (start_go) begin
               busy_q    <= 1'b1;
               msb_q     <= cfg_msb_first;
               idle_q    <= cfg_idle_lvl;
               inv_q     <= cfg_invert;
               lanes_q   <= lanes_live;
               wlen_q    <= wsz_live;
               tx_word_q <= tx_data;
               rx_acc_q  <= '0;
               bit_idx_q <= '0;
               word_n_q  <= ws_n;
               left_q    <= ws_rest;
            end
         end else if (shift_en) begin
            if (!word_end) begin
               bit_idx_q <= IDX_W'(step_end);
               rx_acc_q  <= rx_next;
            end else begin
               rx_data_q  <= rx_next;
               rx_valid_q <= 1'b1;
               if (!more) begin
                  busy_q <= 1'b0;
               end else if (tx_valid) begin
                  tx_word_q <= tx_data;
                  rx_acc_q  <= '0;
                  bit_idx_q <= '0;
                  word_n_q  <= ws_n;
                  left_q    <= ws_rest;
               end else begin
                  busy_q     <= 1'b0;
                  underrun_q <= 1'b1;
               end
            end
         end
      end
   end

   assign busy     = busy_q;
   assign rx_data  = rx_data_q;
   assign rx_valid = rx_valid_q;
   assign underrun = underrun_q;

   // R13: an accepted word at the frame start makes the engine busy
   a_r13_accept_starts : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !busy_q) |=> busy_q);

   // R8: gate code 0 never lets a frame begin
   a_r8_off_no_start : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && cfg_gate == 2'd0) |=> !busy_q);

   // R9: the current word length lies within the latched word size
   a_r9_word_bounds : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (word_n_q != '0 && word_n_q <= wlen_q));

   // R12: an underrun pulse follows a frame that was running and has ended
   a_r12_underrun_ends : assert property (@(posedge clk) disable iff (!rst_n)
      underrun_q |-> (!busy_q && $past(busy_q)));

   // R10: received words only come from an active frame
   a_r10_rx_in_frame : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_q |-> $past(busy_q));

endmodule

// File: tb/mlane_shift_engine_bench.sv
module mlane_shift_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_msb_first = 1'b0;
   logic        cfg_idle_lvl = 1'b0;
   logic [1:0]  cfg_lane_mode = 2'd0;
   logic        cfg_invert = 1'b0;
   logic [1:0]  cfg_gate = 2'd0;
   logic [5:0]  cfg_frame_len = 6'd0;
   logic [3:0]  cfg_word_len = 4'd0;
   logic        shift_en = 1'b0;
   logic        sctl = 1'b0;
   logic [15:0] tx_data = 16'h0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [15:0] rx_data;
   logic        rx_valid;
   logic [3:0]  din = 4'h0;
   logic [3:0]  dout;
   logic        busy;
   logic        underrun;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mlane_shift_engine u_mlane_shift_engine (
      .clk(clk), .rst_n(rst_n),
      .cfg_msb_first(cfg_msb_first), .cfg_idle_lvl(cfg_idle_lvl),
      .cfg_lane_mode(cfg_lane_mode), .cfg_invert(cfg_invert),
      .cfg_gate(cfg_gate), .cfg_frame_len(cfg_frame_len),
      .cfg_word_len(cfg_word_len), .shift_en(shift_en), .sctl(sctl),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .din(din), .dout(dout),
      .busy(busy), .underrun(underrun)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_all();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_all();
   end

   function automatic int lanes_of(input logic [1:0] c);
      return (c == 2'd2) ? 2 : (c == 2'd3) ? 4 : 1;
   endfunction

   function automatic logic [3:0] exp_dout(input logic [15:0] wd, input int n, input int g,
                                           input int nl, input bit msb, input bit inv,
                                           input bit idle);
      logic [3:0] v;
      for (int k = 0; k < 4; k++) begin
         int i;
         i = g * nl + k;
         if (k >= nl || i >= n) v[k] = idle;
         else v[k] = wd[msb ? (n - 1 - i) : i] ^ inv;
      end
      return v;
   endfunction

   task automatic tick_only();
      @(negedge clk) shift_en = 1'b1;
      @(negedge clk) shift_en = 1'b0;
   endtask

   // one frame, checked group by group; avail = transmit words on offer
   task automatic run_frame(input string tag, input bit msb, input bit idle,
                            input logic [1:0] lcode, input bit inv, input int wcode,
                            input int fcode, input logic [1:0] gate, input int avail,
                            input bit scramble);
      logic [15:0] txw [64];
      int tb, wb, nl, needed;
      for (int i = 0; i < 64; i++) txw[i] = 16'($urandom);
      tb = fcode + 1;
      wb = wcode + 1;
      nl = lanes_of(lcode);
      needed = (tb + wb - 1) / wb;

      @(negedge clk);
      cfg_msb_first = msb; cfg_idle_lvl = idle; cfg_lane_mode = lcode;
      cfg_invert = inv; cfg_gate = gate; cfg_frame_len = 6'(fcode);
      cfg_word_len = 4'(wcode);
      tx_data = txw[0]; tx_valid = 1'b1;
      if (gate == 2'd1) sctl = 1'b1;
      else if (gate == 2'd2) sctl = 1'b0;
      else begin
         sctl = ~sctl;
         @(negedge clk);
      end
      @(negedge clk);
      chk("R6", "idle dout before frame", int'(dout), int'({4{idle}}));
      shift_en = 1'b1;
      #1 chk("R13", "tx_ready at start", int'(tx_ready), 1);
      @(negedge clk) shift_en = 1'b0;
      chk("R8", "busy after permitted start", int'(busy), 1);
      if (scramble) begin
         cfg_msb_first = ~msb; cfg_idle_lvl = ~idle; cfg_lane_mode = lcode + 2'd1;
         cfg_invert = ~inv; cfg_frame_len = 6'($urandom);
         cfg_word_len = 4'($urandom);
      end

      for (int w = 0; w < needed; w++) begin
         int n, steps;
         logic [15:0] exp_rx;
         n = (tb - w * wb < wb) ? (tb - w * wb) : wb;
         steps = (n + nl - 1) / nl;
         exp_rx = 16'h0;
         tx_valid = (w + 1 < avail) && (w + 1 < needed);
         tx_data = txw[w + 1];
         for (int g = 0; g < steps; g++) begin
            bit last;
            last = (g == steps - 1);
            @(negedge clk);
            chk(scramble ? "R11" : tag, $sformatf("dout word %0d step %0d", w, g),
                int'(dout), int'(exp_dout(txw[w], n, g, nl, msb, inv, idle)));
            din = 4'($urandom);
            for (int k = 0; k < nl; k++) begin
               int i;
               i = g * nl + k;
               if (i < n) exp_rx[msb ? (n - 1 - i) : i] = din[k];
            end
            if (last && w == needed - 1 && scramble) begin
               cfg_msb_first = msb; cfg_idle_lvl = idle; cfg_lane_mode = lcode;
               cfg_invert = inv; cfg_frame_len = 6'(fcode); cfg_word_len = 4'(wcode);
            end
            shift_en = 1'b1;
            #1 chk("R13", "tx_ready during frame", int'(tx_ready),
                   int'(last && (w + 1 < needed)));
            @(negedge clk) shift_en = 1'b0;
            if (last) begin
               chk("R10", "rx_valid at word end", int'(rx_valid), 1);
               chk("R10", "rx_data", int'(rx_data), int'(exp_rx));
               if (w + 1 < needed && w + 1 >= avail) begin
                  chk("R12", "underrun pulse", int'(underrun), 1);
                  chk("R12", "busy after underrun", int'(busy), 0);
                  chk("R12", "dout passive after underrun", int'(dout), int'({4{idle}}));
                  @(negedge clk);
                  chk("R12", "underrun one cycle", int'(underrun), 0);
                  return;
               end
            end else begin
               chk("R10", "rx_valid mid word", int'(rx_valid), 0);
            end
         end
      end
      chk("R9", "frame ends after programmed bits", int'(busy), 0);
      chk("R12", "no underrun on full frame", int'(underrun), 0);
      chk("R6", "idle dout after frame", int'(dout), int'({4{idle}}));
   endtask

   // a one-bit frame attempt under a gating rule
   task automatic try_gate(input string what, input logic [1:0] gate, input bit lvl,
                           input bit toggle, input bit expect_go);
      @(negedge clk);
      cfg_gate = gate; cfg_frame_len = 6'd0; cfg_word_len = 4'd0;
      cfg_lane_mode = 2'd0; tx_valid = 1'b1; tx_data = 16'h1;
      if (toggle) sctl = ~sctl; else sctl = lvl;
      @(negedge clk);
      @(negedge clk);
      shift_en = 1'b1;
      #1 chk("R8", {what, " tx_ready"}, int'(tx_ready), int'(expect_go));
      @(negedge clk) shift_en = 1'b0;
      chk("R8", {what, " busy"}, int'(busy), int'(expect_go));
      if (expect_go) begin
         tick_only();
         chk("R8", {what, " frame done"}, int'(busy), 0);
      end
      tx_valid = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset dout", int'(dout), 0);
      chk("R1", "reset busy", int'(busy), 0);
      chk("R1", "reset rx_valid", int'(rx_valid), 0);
      chk("R1", "reset underrun", int'(underrun), 0);
      chk("R1", "reset rx_data", int'(rx_data), 0);
      tx_valid = 1'b1; shift_en = 1'b1;
      #1 chk("R1", "reset gate blocks tx_ready", int'(tx_ready), 0);
      @(negedge clk) shift_en = 1'b0;
      chk("R1", "reset no frame", int'(busy), 0);
      tx_valid = 1'b0;

      // gating rules
      try_gate("off high", 2'd0, 1'b1, 1'b0, 1'b0);
      try_gate("off low", 2'd0, 1'b0, 1'b0, 1'b0);
      try_gate("high w/ 0", 2'd1, 1'b0, 1'b0, 1'b0);
      try_gate("high w/ 1", 2'd1, 1'b1, 1'b0, 1'b1);
      try_gate("low w/ 1", 2'd2, 1'b1, 1'b0, 1'b0);
      try_gate("low w/ 0", 2'd2, 1'b0, 1'b0, 1'b1);
      try_gate("edge toggled", 2'd3, 1'b0, 1'b1, 1'b1);
      try_gate("edge consumed", 2'd3, sctl, 1'b0, 1'b0);

      // directed frames
      run_frame("R2", 0, 0, 2'd0, 0, 7, 7, 2'd1, 64, 0);
      run_frame("R3", 1, 1, 2'd0, 0, 4, 4, 2'd1, 64, 0);
      run_frame("R5", 0, 0, 2'd2, 0, 6, 6, 2'd2, 64, 0);
      run_frame("R7", 1, 0, 2'd3, 1, 15, 15, 2'd1, 64, 0);
      run_frame("R5", 0, 1, 2'd3, 0, 5, 5, 2'd3, 64, 0);
      run_frame("R5", 1, 1, 2'd1, 1, 3, 3, 2'd1, 64, 0);
      run_frame("R9", 1, 0, 2'd2, 0, 9, 24, 2'd1, 64, 0);
      run_frame("R4", 0, 0, 2'd0, 1, 15, 63, 2'd1, 64, 0);
      run_frame("R4", 1, 1, 2'd0, 0, 0, 2, 2'd1, 64, 0);
      run_frame("R11", 0, 0, 2'd2, 0, 8, 20, 2'd1, 64, 1);
      run_frame("R12", 0, 1, 2'd0, 0, 9, 29, 2'd1, 1, 0);
      run_frame("R12", 1, 0, 2'd3, 1, 3, 15, 2'd3, 2, 0);

      // random frames
      for (int r = 0; r < 16; r++) begin
         int lsel;
         logic [1:0] lc;
         lsel = $urandom % 3;
         lc = (lsel == 0) ? 2'd0 : (lsel == 1) ? 2'd2 : 2'd3;
         run_frame("R9", 1'($urandom), 1'($urandom), lc, 1'($urandom),
                   $urandom % 16, $urandom % 48, 2'(1 + $urandom % 3), 64,
                   1'($urandom));
      end

      repeat (4) @(negedge clk);
      finish_all();
   end

endmodule